// File: doc/BRIEF.md
# Flash Erase Abort Sequencer

This block cancels an automatic chip erase that a flash controller is already running. A one-cycle `start` pulse launches a fixed handshake. The block is the only master on a simple register bus (address, write data, write strobe, read strobe, read data, acknowledge). Over that bus it reaches the controller's two status registers, its control register, its key register, its status-clear register and its command address. When the handshake ends, `done` pulses for one cycle. `abort_seen` then shows whether the controller's abort flag was found set, and `error` shows whether a poll loop ran out of attempts.

The states are as follows.
- IDLE waits for `start`.
- CHK reads status 0. If the ready bit is set, CHK goes to DONE; if it is clear, it goes to KEY1.
- KEY1 writes the key and then moves to ASET. ASET writes the abort field as 7 in the control register and moves to KEY2.
- KEY2 writes the key again and moves to AZERO. AZERO writes the abort field as 0 and moves to POLLR.
- POLLR reads status 0 again and again. When the ready bit reads 1 it moves to FLAG. When the attempt limit is used up it moves to FAIL.
- FLAG reads status 1, latches the abort bit and moves to CMD.
- CMD writes the read/reset command word. It then goes to CSET if the latched bit is 1, or to DONE if it is 0.
- CSET writes 7 to the abort field of the status-clear register and moves to CZERO. CZERO writes 0 there and moves to POLLF.
- POLLF reads status 1 again and again. When the abort bit reads 0 it moves to DONE. When the limit is used up it moves to FAIL.
- DONE and FAIL each last one cycle and then return to IDLE.

Every state that uses the bus starts one transaction and waits for its acknowledge before it moves on.

Top module: `erase_abort_seq`

## Requirements
- R1: When the first read of status 0 returns the ready bit (bit RDY_BIT, default 0) as 1, the block makes no writes and performs exactly one read. It then pulses `done`, with `error` low and `abort_seen` low.
- R2: When the first read shows busy, the block writes four words in this order: KEY_VAL to KEY_ADDR, then 7 in the 3-bit field at ABT_LSB (default 4) of CTRL_ADDR, then KEY_VAL to KEY_ADDR again, then 0 to CTRL_ADDR. Every control write comes directly after a key write.
- R3: After the abort pulse, the block reads STAT0_ADDR until the ready bit reads 1. Other bits of the read data are ignored.
- R4: The block then reads STAT1_ADDR once, and `abort_seen` takes the value of bit ABT_BIT (default 2). `abort_seen` holds that value until the next accepted start, which clears it.
- R5: After the status 1 read, the block writes CMD_VAL to CMD_ADDR.
- R6: If the latched abort bit is 1, the block writes 7 and then 0 in the abort field of CLR_ADDR. It then reads STAT1_ADDR until the abort bit reads 0. If the latched bit is 0, the block writes nothing to CLR_ADDR.
- R7: A bus strobe stays asserted, with its address and data unchanged, until `bus_ack` is seen. Write and read are never asserted together, and one transaction is outstanding at a time.
- R8: Each poll loop makes at most POLL_MAX reads. If the last of those reads still fails, the block stops the sequence, sets `error` and pulses `done`. `error` stays set until the next accepted start clears it.
- R9: `done` is high for exactly one cycle per sequence. A `start` that arrives while `busy` is high is ignored.
- R10: After reset the block is idle: `busy`, `done`, `error`, `abort_seen`, `bus_wr` and `bus_rd` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that launches the abort sequence |
| busy | output | 1 | High while the sequence runs |
| done | output | 1 | One-cycle pulse at the end of the sequence |
| error | output | 1 | Sticky: a poll loop exceeded POLL_MAX |
| abort_seen | output | 1 | Sticky: the abort flag in status 1 was read as 1 |
| bus_addr | output | AW | Register address |
| bus_wdata | output | DW | Write data |
| bus_wr | output | 1 | Write strobe, held until acknowledge |
| bus_rd | output | 1 | Read strobe, held until acknowledge |
| bus_rdata | input | DW | Read data, valid with acknowledge |
| bus_ack | input | 1 | Transaction acknowledge |

## Verification
The bench sweeps a grid of controller behaviours and computes the expected write list, read count and flags for each point.
- **Ready at the first read.** Shows the early exit apart from the full handshake.
- **Number of busy polls, from 0 to past the limit.** Shows normal completion apart from the ready timeout.
- **Abort flag 0 or 1.** Shows whether the clear pulse is skipped or taken.
- **Number of flag-clear polls, including past the limit.** Tests the second timeout.
- **Acknowledge latency of 0 to 2 cycles.** Tests that each strobe is held until acknowledged.

In addition:
- A second `start` is injected in the middle of every busy run. It must change neither the write list nor the count of `done` pulses.
- Read data carries junk in the unrelated bits to show that only the named bits are decoded.

// File: rtl/abort_pkg.sv
package abort_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_CHK, S_KEY1, S_ASET, S_KEY2, S_AZERO, S_POLLR,
        S_FLAG, S_CMD, S_CSET, S_CZERO, S_POLLF, S_DONE, S_FAIL
    } seq_state_t;

    typedef enum logic [2:0] {
        OP_RD_S0, OP_RD_S1, OP_KEY, OP_CTRL_SET, OP_CTRL_ZERO,
        OP_CMD, OP_CLR_SET, OP_CLR_ZERO
    } bus_op_t;

endpackage

// File: rtl/abort_bus_port.sv
module abort_bus_port #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          go_wr,
    input  logic [AW-1:0] go_addr,
    input  logic [DW-1:0] go_data,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_wr,
    output logic          bus_rd,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    output logic          fin,
    output logic [DW-1:0] rd_val
);
    logic act_q, wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q     <= 1'b0;
            wr_q      <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            fin       <= 1'b0;
            rd_val    <= '0;
        end else begin
            fin <= 1'b0;
            if (act_q && bus_ack) begin
                act_q  <= 1'b0;
                fin    <= 1'b1;
                rd_val <= bus_rdata;
            end else if (go && !act_q) begin
                act_q     <= 1'b1;
                wr_q      <= go_wr;
                bus_addr  <= go_addr;
                bus_wdata <= go_data;
            end
        end
    end

    assign bus_wr = act_q && wr_q;
    assign bus_rd = act_q && !wr_q;

    p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    p_hold_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) && !bus_ack |=>
        (bus_wr || bus_rd) && $stable(bus_addr) && $stable(bus_wdata));

endmodule

// File: rtl/abort_poll_limit.sv
module abort_poll_limit #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr)   cnt_q <= '0;
        else if (step && !last) cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == CW'(LIMIT - 1));

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT - 1));

endmodule

// File: rtl/erase_abort_seq.sv
module erase_abort_seq
    import abort_pkg::*;
#(
    parameter int          AW         = 8,
    parameter int          DW         = 32,
    parameter logic [7:0]  STAT0_ADDR = 8'h00,
    parameter logic [7:0]  STAT1_ADDR = 8'h04,
    parameter logic [7:0]  CTRL_ADDR  = 8'h10,
    parameter logic [7:0]  CLR_ADDR   = 8'h14,
    parameter logic [7:0]  KEY_ADDR   = 8'h20,
    parameter logic [7:0]  CMD_ADDR   = 8'h30,
    parameter logic [31:0] KEY_VAL    = 32'hA5A5_1234,
    parameter logic [31:0] CMD_VAL    = 32'h0000_00F0,
    parameter int          RDY_BIT    = 0,
    parameter int          ABT_BIT    = 2,
    parameter int          ABT_LSB    = 4,
    parameter int          POLL_MAX   = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic          abort_seen,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_wr,
    output logic          bus_rd,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack
);
    localparam logic [DW-1:0] FIELD_ON = DW'(7) << ABT_LSB;

    seq_state_t    state_q;
    bus_op_t       op;
    logic          issue, pend_q, go, fin, last, in_poll;
    logic          go_wr;
    logic [AW-1:0] go_addr;
    logic [DW-1:0] go_data, rd_val;
    logic          err_q, abt_q;

    // state register and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pend_q  <= 1'b0;
            err_q   <= 1'b0;
            abt_q   <= 1'b0;
        end else begin
            if (go)  pend_q <= 1'b1;
            if (fin) pend_q <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start) begin
                    state_q <= S_CHK;
                    err_q   <= 1'b0;
                    abt_q   <= 1'b0;
                end
                S_CHK:   if (fin) state_q <= rd_val[RDY_BIT] ? S_DONE : S_KEY1;
                S_KEY1:  if (fin) state_q <= S_ASET;
                S_ASET:  if (fin) state_q <= S_KEY2;
                S_KEY2:  if (fin) state_q <= S_AZERO;
                S_AZERO: if (fin) state_q <= S_POLLR;
                S_POLLR: if (fin) begin
                    if (rd_val[RDY_BIT]) state_q <= S_FLAG;
                    else if (last) begin
                        state_q <= S_FAIL;
                        err_q   <= 1'b1;
                    end
                end
                S_FLAG: if (fin) begin
                    abt_q   <= rd_val[ABT_BIT];
                    state_q <= S_CMD;
                end
                S_CMD:   if (fin) state_q <= abt_q ? S_CSET : S_DONE;
                S_CSET:  if (fin) state_q <= S_CZERO;
                S_CZERO: if (fin) state_q <= S_POLLF;
                S_POLLF: if (fin) begin
                    if (!rd_val[ABT_BIT]) state_q <= S_DONE;
                    else if (last) begin
                        state_q <= S_FAIL;
                        err_q   <= 1'b1;
                    end
                end
                S_DONE, S_FAIL: state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // outputs: which bus operation each state performs
    always_comb begin
        issue = 1'b1;
        op    = OP_RD_S0;
        unique case (state_q)
            S_CHK, S_POLLR:  op = OP_RD_S0;
            S_FLAG, S_POLLF: op = OP_RD_S1;
            S_KEY1, S_KEY2:  op = OP_KEY;
            S_ASET:          op = OP_CTRL_SET;
            S_AZERO:         op = OP_CTRL_ZERO;
            S_CMD:           op = OP_CMD;
            S_CSET:          op = OP_CLR_SET;
            S_CZERO:         op = OP_CLR_ZERO;
            default:         issue = 1'b0;
        endcase
    end

    always_comb begin
        go_wr   = 1'b1;
        go_addr = '0;
        go_data = '0;
        unique case (op)
            OP_RD_S0:     begin go_wr = 1'b0; go_addr = AW'(STAT0_ADDR); end
            OP_RD_S1:     begin go_wr = 1'b0; go_addr = AW'(STAT1_ADDR); end
            OP_KEY:       begin go_addr = AW'(KEY_ADDR);  go_data = DW'(KEY_VAL); end
            OP_CTRL_SET:  begin go_addr = AW'(CTRL_ADDR); go_data = FIELD_ON; end
            OP_CTRL_ZERO: begin go_addr = AW'(CTRL_ADDR); end
            OP_CMD:       begin go_addr = AW'(CMD_ADDR);  go_data = DW'(CMD_VAL); end
            OP_CLR_SET:   begin go_addr = AW'(CLR_ADDR);  go_data = FIELD_ON; end
            OP_CLR_ZERO:  begin go_addr = AW'(CLR_ADDR); end
            default:      go_wr = 1'b0;
        endcase
    end

    assign go         = issue && !pend_q;
    assign in_poll    = (state_q == S_POLLR) || (state_q == S_POLLF);
    assign busy       = (state_q != S_IDLE);
    assign done       = (state_q == S_DONE) || (state_q == S_FAIL);
    assign error      = err_q;
    assign abort_seen = abt_q;

    abort_bus_port #(.AW(AW), .DW(DW)) u_port (
        .clk(clk), .rst_n(rst_n), .go(go), .go_wr(go_wr), .go_addr(go_addr),
        .go_data(go_data), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .fin(fin), .rd_val(rd_val)
    );

    abort_poll_limit #(.LIMIT(POLL_MAX)) u_limit (
        .clk(clk), .rst_n(rst_n), .clr(!in_poll), .step(fin && in_poll),
        .last(last)
    );

    // snoop of acknowledged writes: was the previous write the key?
    logic key_armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) key_armed <= 1'b0;
        else if (bus_wr && bus_ack)
            key_armed <= (bus_addr == AW'(KEY_ADDR)) && (bus_wdata == DW'(KEY_VAL));
    end

    p_key_before_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && (bus_addr == AW'(CTRL_ADDR)) |-> key_armed);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> done);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_wr && !bus_rd);

endmodule

// File: tb/sim_erase_abort_seq.sv
module sim_erase_abort_seq;
    localparam int          PM    = 4;
    localparam logic [7:0]  A_S0  = 8'h00, A_S1 = 8'h04, A_CTRL = 8'h10;
    localparam logic [7:0]  A_CLR = 8'h14, A_KEY = 8'h20, A_CMD = 8'h30;
    localparam logic [31:0] KEYV  = 32'hA5A5_1234, CMDV = 32'h0000_00F0;
    localparam logic [31:0] ON7   = 32'h70;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic busy, done, error, abort_seen, bus_wr, bus_rd;
    logic bus_ack = 1'b0;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;

    always #2.5 clk = ~clk;

    erase_abort_seq #(.POLL_MAX(PM)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .error(error), .abort_seen(abort_seen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    int n_chk = 0, n_bad = 0;

    // controller model configuration
    int cfg_lat = 0, cfg_busy = 0, cfg_clr = 0;
    bit cfg_ready = 0, cfg_flag = 0;
    // observed activity
    int   waitc = 0, n_rd = 0, n_wr = 0, proto = 0, s0p = 0, s1p = 0, n_done = 0;
    bit   ab_done = 0, cl_done = 0;
    logic [7:0]  hold_a = '0;
    logic [7:0]  log_a [16];
    logic [31:0] log_d [16];

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (done) n_done++;
        if (!rst_n) begin
            bus_ack = 1'b0; waitc = 0;
        end else if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_wr || bus_rd) begin
            if (bus_wr && bus_rd) proto++;
            if (waitc > 0 && bus_addr != hold_a) proto++;
            hold_a = bus_addr;
            if (waitc >= cfg_lat) begin
                bus_ack = 1'b1; waitc = 0;
                bus_rdata = 32'h5A00_0F0A & ~32'h5;
                if (bus_wr) begin
                    if (n_wr < 16) begin log_a[n_wr] = bus_addr; log_d[n_wr] = bus_wdata; end
                    n_wr++;
                    if (bus_addr == A_CTRL && bus_wdata == 0) ab_done = 1;
                    if (bus_addr == A_CLR  && bus_wdata == 0) cl_done = 1;
                end else begin
                    n_rd++;
                    if (bus_addr == A_S0) begin
                        if (cfg_ready) bus_rdata[0] = 1'b1;
                        else if (ab_done) begin
                            bus_rdata[0] = (s0p >= cfg_busy); s0p++;
                        end
                    end else if (bus_addr == A_S1) begin
                        if (!cl_done) bus_rdata[2] = cfg_flag;
                        else begin bus_rdata[2] = (s1p < cfg_clr); s1p++; end
                    end
                end
            end else waitc++;
        end else if (waitc != 0) begin
            proto++; waitc = 0;
        end
    end

    task automatic run(input bit rdy, input int bp, input bit fl, input int cp, input int lat);
        logic [7:0]  ea [8];
        logic [31:0] ed [8];
        int ne = 0, er = 1, t = 0;
        bit fail_r, fail_f, e_err, e_abt;
        cfg_ready = rdy; cfg_busy = bp; cfg_flag = fl; cfg_clr = cp; cfg_lat = lat;
        n_rd = 0; n_wr = 0; proto = 0; s0p = 0; s1p = 0; n_done = 0;
        ab_done = 0; cl_done = 0;
        fail_r = !rdy && bp >= PM;
        fail_f = !rdy && !fail_r && fl && cp >= PM;
        e_err  = fail_r || fail_f;
        e_abt  = !rdy && !fail_r && fl;
        if (!rdy) begin
            ea[0] = A_KEY; ed[0] = KEYV; ea[1] = A_CTRL; ed[1] = ON7;
            ea[2] = A_KEY; ed[2] = KEYV; ea[3] = A_CTRL; ed[3] = 0; ne = 4;
            er += fail_r ? PM : bp + 1;
            if (!fail_r) begin
                er++;
                ea[4] = A_CMD; ed[4] = CMDV; ne = 5;
                if (fl) begin
                    ea[5] = A_CLR; ed[5] = ON7; ea[6] = A_CLR; ed[6] = 0; ne = 7;
                    er += fail_f ? PM : cp + 1;
                end
            end
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R4 abort_seen cleared by start", abort_seen, 0);
        check("R8 error cleared by start", error, 0);
        if (!rdy) begin
            repeat (3) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;  // R9 ignored start
        end
        while (n_done == 0 && t < 400) begin @(negedge clk); t++; end
        repeat (6) @(negedge clk);
        check("R9 one done pulse", n_done, 1);
        check("R8 error flag", error, e_err);
        check("R4 abort_seen value", abort_seen, e_abt);
        check("R3 R6 R8 read count", n_rd, er);
        check("R1 R2 R5 R6 write count", n_wr, ne);
        for (int i = 0; i < ne && i < n_wr; i++) begin
            check("R2 R5 R6 write address", log_a[i], ea[i]);
            check("R2 R5 R6 write data", log_d[i], ed[i]);
        end
        check("R7 bus handshake", proto, 0);
        check("R10 idle after run", {busy, bus_wr, bus_rd}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset busy", busy, 0);
        check("R10 reset done", done, 0);
        check("R10 reset error", error, 0);
        check("R10 reset abort_seen", abort_seen, 0);
        check("R10 reset strobes", {bus_wr, bus_rd}, 0);
        rst_n = 1'b1;
        for (int lat = 0; lat < 3; lat++) begin
            run(1'b1, 0, 1'b1, 0, lat);  // R1 early exit
            for (int bp = 0; bp <= PM; bp++) begin
                run(1'b0, bp, 1'b0, 0, lat);
                for (int cp = 0; cp <= PM; cp++) run(1'b0, bp, 1'b1, cp, lat);
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule